// File: doc/BRIEF.md
# Store Miss Merging Buffer

This block sits between a load/store unit and the next cache level and collects store misses on their way out. A store that has executed but is not yet committed is held in a three-entry finished queue. Each commit pulse moves the oldest finished store into a five-entry completed queue. On the way in, the store is merged byte by byte into a waiting completed entry for the same 32-byte line. If there is no such entry, it takes a new one.

The oldest completed entry is offered downstream with a valid/ready handshake, and entries leave in program order. An entry whose merged byte mask covers the whole line goes out as an address-only ownership request with no data. A partly covered line goes out with its byte mask and the merged data. The entry being offered is locked, so later stores to that line start a new entry. A flush discards every speculative store still in the finished queue and leaves committed work alone. Two stall outputs tell the load/store unit when a store or a commit cannot be taken.

Top module: `store_merge_buffer`

## Requirements
- R1: A store is taken into the finished queue on a clock edge where `st_valid` is high and `st_stall` is low. `st_stall` is high exactly while the finished queue holds 3 stores, and a store offered during a stall is dropped.
- R2: On an edge with `cmt_valid` high, the oldest finished store moves into the completed queue. A commit is ignored when the finished queue is empty or `cmt_stall` is high. A moved store can be offered on `req_*` right after that same edge.
- R3: A committed store whose line address equals that of a waiting completed entry other than the one being offered merges into that entry. The byte masks are ORed, and the newer store's bytes replace older bytes wherever its mask is set.
- R4: The completed entry currently offered downstream (the oldest) never takes a merge. A commit that matches only that entry allocates a new entry behind it.
- R5: `cmt_stall` is high only when the finished queue is non-empty, the completed queue holds 5 entries, and the oldest finished store has no mergeable match. A store that can merge is still accepted into a full completed queue.
- R6: `req_valid` is high while the completed queue is non-empty and shows its oldest entry. The entry leaves on an edge with `req_valid` and `req_ready` both high. Requests appear in commit order and hold steady while `req_ready` is low.
- R7: A request whose byte mask is not all ones has `req_addr_only` low. It carries the merged mask on `req_be`, with bit i covering data bits [8i+7:8i], and the merged data on `req_data`. Bytes never written read as zero.
- R8: A request whose mask covers all 32 bytes has `req_addr_only` high, `req_be` all ones and `req_data` all zero.
- R9: `flush` empties the finished queue on that edge, including any store or commit offered in the same cycle. Completed entries are untouched and still drain.
- R10: After reset both queues are empty, so `st_stall`, `cmt_stall` and `req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered from the load/store unit |
| st_addr | input | ADDR_W | Line address of the store |
| st_be | input | 32 | Byte enables within the line |
| st_data | input | 256 | Store data placed at line byte positions |
| st_stall | output | 1 | Finished queue full; store not taken |
| cmt_valid | input | 1 | Commit the oldest finished store |
| cmt_stall | output | 1 | Commit cannot be taken this cycle |
| flush | input | 1 | Discard all uncommitted stores |
| req_valid | output | 1 | Downstream request present |
| req_ready | input | 1 | Downstream accepts the request |
| req_addr | output | ADDR_W | Line address of the request |
| req_be | output | 32 | Merged byte mask |
| req_data | output | 256 | Merged data; zero for address-only |
| req_addr_only | output | 1 | Ownership request with no data phase |

## Verification
Stall outputs depend only on stored state, so they are due as soon as the state-changing edge has passed. A store appears in the finished queue one edge after it is driven. A commit on edge k makes its request visible on `req_*` after edge k, with no further register between them. The bench drives every input on the falling edge and samples all results one nanosecond later, after the edge that caused them. The scoreboard queue is filled by the driver in expected commit order, and the monitor compares an entry each time it sees a valid/ready pair before the rising edge that completes it.

// File: rtl/smb_pkg.sv
package smb_pkg;
  localparam int LINE_BYTES = 32;
  localparam int LINE_BITS  = 8 * LINE_BYTES;

  typedef logic [LINE_BYTES-1:0] be_t;
  typedef logic [LINE_BITS-1:0]  line_t;

  // Replace the bytes of base selected by sel with the bytes of upd.
  function automatic line_t overlay_bytes(line_t base, line_t upd, be_t sel);
    line_t r;
    r = base;
    for (int b = 0; b < LINE_BYTES; b++) begin
      if (sel[b]) r[8*b +: 8] = upd[8*b +: 8];
    end
    return r;
  endfunction

  // A line is fully covered when every byte enable is set.
  function automatic logic covers_line(be_t be);
    return &be;
  endfunction
endpackage

// File: rtl/smb_fq.sv
module smb_fq
  import smb_pkg::*;
#(
  parameter int AW    = 27,
  parameter int DEPTH = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  be_t           push_be,
  input  line_t         push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output be_t           head_be,
  output line_t         head_data,
  output logic          full,
  output logic          empty
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] cnt_q, cnt_d, cnt_after_pop;
  logic [AW-1:0] a_q [DEPTH];
  logic [AW-1:0] a_d [DEPTH];
  be_t           b_q [DEPTH];
  be_t           b_d [DEPTH];
  line_t         d_q [DEPTH];
  line_t         d_d [DEPTH];

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    d_d = d_q;
    cnt_after_pop = cnt_q - CW'(pop);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        a_d[i] = a_q[i+1];
        b_d[i] = b_q[i+1];
        d_d[i] = d_q[i+1];
      end
    end
    if (push) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_after_pop) begin
          a_d[i] = push_addr;
          b_d[i] = push_be;
          d_d[i] = push_data;
        end
      end
    end
    cnt_d = flush ? '0 : cnt_after_pop + CW'(push);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    a_q <= a_d;
    b_q <= b_d;
    d_q <= d_d;
  end

  assign full      = (cnt_q == CW'(DEPTH));
  assign empty     = (cnt_q == '0);
  assign head_addr = a_q[0];
  assign head_be   = b_q[0];
  assign head_data = d_q[0];

  // R1
  fq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R2
  fq_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9
  fq_flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/smb_cq.sv
module smb_cq
  import smb_pkg::*;
#(
  parameter int AW    = 27,
  parameter int DEPTH = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW-1:0] in_addr,
  input  be_t           in_be,
  input  line_t         in_data,
  output logic          accept,
  output logic          stall,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output be_t           head_be,
  output line_t         head_data,
  output logic          nonempty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [CW-1:0] cnt_q, cnt_d, cnt_after_pop;
  logic [AW-1:0] a_q [DEPTH];
  logic [AW-1:0] a_d [DEPTH];
  be_t           b_q [DEPTH];
  be_t           b_d [DEPTH];
  line_t         d_q [DEPTH];
  line_t         d_d [DEPTH];

  logic          hit;
  logic [IW-1:0] hit_idx;
  logic          full;
  logic          do_merge;
  logic          do_alloc;

  // Search waiting entries only; slot 0 is offered downstream and locked.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = 1; i < DEPTH; i++) begin
      if (CW'(i) < cnt_q && a_q[i] == in_addr) begin
        hit     = 1'b1;
        hit_idx = IW'(i);
      end
    end
  end

  assign full     = (cnt_q == CW'(DEPTH));
  assign stall    = full && !hit;
  assign accept   = in_valid && !stall;
  assign do_merge = accept && hit;
  assign do_alloc = accept && !hit;

  always_comb begin
    a_d = a_q;
    b_d = b_q;
    d_d = d_q;
    // merge first, on pre-shift positions (never slot 0, so a pop cannot lose it)
    if (do_merge) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (hit_idx == IW'(i)) begin
          b_d[i] = b_q[i] | in_be;
          d_d[i] = overlay_bytes(d_q[i], in_data, in_be);
        end
      end
    end
    cnt_after_pop = cnt_q - CW'(pop);
    if (pop) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        a_d[i] = a_d[i+1];
        b_d[i] = b_d[i+1];
        d_d[i] = d_d[i+1];
      end
    end
    if (do_alloc) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (CW'(i) == cnt_after_pop) begin
          a_d[i] = in_addr;
          b_d[i] = in_be;
          d_d[i] = overlay_bytes('0, in_data, in_be);
        end
      end
    end
    cnt_d = cnt_after_pop + CW'(do_alloc);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    a_q <= a_d;
    b_q <= b_d;
    d_q <= d_d;
  end

  assign nonempty  = (cnt_q != '0);
  assign head_addr = a_q[0];
  assign head_be   = b_q[0];
  assign head_data = d_q[0];

  // R3
  cq_merge_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_merge && !pop) |=> (cnt_q == $past(cnt_q)));
  // R5
  cq_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> (cnt_q == CW'(DEPTH)));
  // R6
  cq_pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> nonempty);
endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer
  import smb_pkg::*;
#(
  parameter int ADDR_W   = 27,
  parameter int FQ_DEPTH = 3,
  parameter int CQ_DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [31:0]       st_be,
  input  logic [255:0]      st_data,
  output logic              st_stall,
  input  logic              cmt_valid,
  output logic              cmt_stall,
  input  logic              flush,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_be,
  output logic [255:0]      req_data,
  output logic              req_addr_only
);
  logic              fq_full, fq_empty;
  logic              fq_push, fq_pop;
  logic [ADDR_W-1:0] fq_addr;
  be_t               fq_be;
  line_t             fq_data;

  logic              cq_in_valid, cq_accept, cq_stall, cq_pop, cq_nonempty;
  logic [ADDR_W-1:0] cq_addr;
  be_t               cq_be;
  line_t             cq_data;

  // Named events for assertions
  logic              store_taken;
  logic              commit_taken;
  logic              req_fire;

  assign fq_push      = st_valid && !fq_full && !flush;
  assign cq_in_valid  = cmt_valid && !fq_empty && !flush;
  assign fq_pop       = cq_accept;
  assign store_taken  = fq_push;
  assign commit_taken = cq_accept;

  smb_fq #(.AW(ADDR_W), .DEPTH(FQ_DEPTH)) u_fq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .push      (fq_push),
    .push_addr (st_addr),
    .push_be   (st_be),
    .push_data (st_data),
    .pop       (fq_pop),
    .head_addr (fq_addr),
    .head_be   (fq_be),
    .head_data (fq_data),
    .full      (fq_full),
    .empty     (fq_empty)
  );

  smb_cq #(.AW(ADDR_W), .DEPTH(CQ_DEPTH)) u_cq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cq_in_valid),
    .in_addr   (fq_addr),
    .in_be     (fq_be),
    .in_data   (fq_data),
    .accept    (cq_accept),
    .stall     (cq_stall),
    .pop       (cq_pop),
    .head_addr (cq_addr),
    .head_be   (cq_be),
    .head_data (cq_data),
    .nonempty  (cq_nonempty)
  );

  assign st_stall      = fq_full;
  assign cmt_stall     = !fq_empty && cq_stall;
  assign req_valid     = cq_nonempty;
  assign req_fire      = req_valid && req_ready;
  assign cq_pop        = req_fire;
  assign req_addr      = cq_addr;
  assign req_be        = cq_be;
  assign req_addr_only = covers_line(cq_be);
  assign req_data      = req_addr_only ? '0 : cq_data;

  // R2
  commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_taken |=> req_valid);
  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)
      && $stable(req_be) && $stable(req_data)));
  // R1
  stall_blocks_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_stall && !commit_taken && !flush) |=> st_stall);
  // R9
  flush_clears_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!st_stall && !cmt_stall));
endmodule

// File: tb/tb_store_merge_buffer.sv
module tb_store_merge_buffer;
  localparam int AW = 27;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           st_valid = 1'b0;
  logic [AW-1:0]  st_addr = '0;
  logic [31:0]    st_be = '0;
  logic [255:0]   st_data = '0;
  logic           st_stall;
  logic           cmt_valid = 1'b0;
  logic           cmt_stall;
  logic           flush = 1'b0;
  logic           req_valid;
  logic           req_ready = 1'b0;
  logic [AW-1:0]  req_addr;
  logic [31:0]    req_be;
  logic [255:0]   req_data;
  logic           req_addr_only;

  store_merge_buffer #(.ADDR_W(AW), .FQ_DEPTH(3), .CQ_DEPTH(5)) dut (.*);

  always #2 clk = ~clk;

  typedef struct {
    logic [AW-1:0] a;
    logic [31:0]   be;
    logic [255:0]  d;
    logic          ao;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0;
  int   n_err = 0;
  bit   done  = 1'b0;

  task automatic chk(bit ok, string tag, logic [255:0] act, logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [255:0] fill(logic [7:0] b);
    return {32{b}};
  endfunction

  // bench view of a byte merge: walk bytes from the top down
  function automatic logic [255:0] put(logic [255:0] old, logic [31:0] be, logic [7:0] b);
    logic [255:0] r;
    r = old;
    for (int k = 31; k >= 0; k--) if (be[k]) r[k*8 +: 8] = b;
    return r;
  endfunction

  task automatic expect_req(logic [AW-1:0] a, logic [31:0] be, logic [255:0] d);
    exp_t e;
    e.a  = a;
    e.be = be;
    e.ao = (be == 32'hFFFF_FFFF);
    e.d  = e.ao ? 256'd0 : d;
    exp_q.push_back(e);
  endtask

  task automatic do_store(logic [AW-1:0] a, logic [31:0] be, logic [7:0] b);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = fill(b);
    @(negedge clk);
    st_valid = 1'b0;
    #1;
  endtask

  task automatic do_store_flush(logic [AW-1:0] a, logic [31:0] be, logic [7:0] b);
    @(negedge clk);
    st_valid = 1'b1; st_addr = a; st_be = be; st_data = fill(b);
    flush = 1'b1; cmt_valid = 1'b1;
    @(negedge clk);
    st_valid = 1'b0; flush = 1'b0; cmt_valid = 1'b0;
    #1;
  endtask

  task automatic do_commit();
    @(negedge clk);
    cmt_valid = 1'b1;
    @(negedge clk);
    cmt_valid = 1'b0;
    #1;
  endtask

  task automatic drain(bit toggle);
    for (int i = 0; i < 400 && exp_q.size() != 0; i++) begin
      @(negedge clk);
      req_ready = toggle ? ~req_ready : 1'b1;
    end
    @(negedge clk);
    req_ready = 1'b0;
    #1;
    chk(exp_q.size() == 0, "R6 all expected requests seen", exp_q.size(), 0);
    chk(req_valid == 1'b0, "R6 queue empty after drain", req_valid, 0);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && req_valid && req_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected request", req_addr, 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk(req_addr == e.a, "R6 order addr", req_addr, e.a);
          chk(req_be == e.be, e.ao ? "R8 be" : "R7 be", req_be, e.be);
          chk(req_data == e.d, e.ao ? "R8 data" : "R7 data", req_data, e.d);
          chk(req_addr_only == e.ao, e.ao ? "R8 flag" : "R7 flag", req_addr_only, e.ao);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0]  acc_be;
    logic [255:0] acc_d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10
    chk(st_stall == 1'b0, "R10 st_stall", st_stall, 0);
    chk(cmt_stall == 1'b0, "R10 cmt_stall", cmt_stall, 0);
    chk(req_valid == 1'b0, "R10 req_valid", req_valid, 0);

    // merging, locked head, full coverage (R3 R4 R7 R8)
    do_store(27'h10, 32'h0000_FFFF, 8'h11); do_commit();
    chk(req_valid == 1'b1, "R2 request after commit", req_valid, 1);
    expect_req(27'h10, 32'h0000_FFFF, put('0, 32'h0000_FFFF, 8'h11));
    do_store(27'h20, 32'h0000_00FF, 8'h22); do_commit();
    acc_be = 32'h0000_00FF; acc_d = put('0, acc_be, 8'h22);
    do_store(27'h20, 32'h0000_FF0F, 8'h33); do_commit();
    acc_be |= 32'h0000_FF0F; acc_d = put(acc_d, 32'h0000_FF0F, 8'h33);
    do_store(27'h10, 32'hFFFF_0000, 8'h44); do_commit();
    do_store(27'h20, 32'hFFFF_0000, 8'h55); do_commit();
    acc_be |= 32'hFFFF_0000; acc_d = put(acc_d, 32'hFFFF_0000, 8'h55);
    chk(req_addr == 27'h10 && req_be == 32'h0000_FFFF, "R4 head not merged", req_be, 32'h0000_FFFF);
    chk(cmt_stall == 1'b0, "R5 no stall with room", cmt_stall, 0);
    expect_req(27'h20, acc_be, acc_d);
    expect_req(27'h10, 32'hFFFF_0000, put('0, 32'hFFFF_0000, 8'h44));
    do_store(27'h30, 32'hFFFF_FFFF, 8'h66); do_commit();
    expect_req(27'h30, 32'hFFFF_FFFF, '0);
    drain(1'b1);

    // finished queue full (R1), commit with empty queue (R2)
    do_store(27'h40, 32'h0000_0001, 8'h71);
    do_store(27'h41, 32'h0000_0003, 8'h72);
    do_store(27'h42, 32'h0000_0007, 8'h73);
    chk(st_stall == 1'b1, "R1 stall at 3 stores", st_stall, 1);
    do_store(27'h43, 32'h0000_000F, 8'h74);
    do_commit(); do_commit(); do_commit();
    chk(st_stall == 1'b0, "R1 stall released", st_stall, 0);
    do_commit();
    expect_req(27'h40, 32'h0000_0001, put('0, 32'h0000_0001, 8'h71));
    expect_req(27'h41, 32'h0000_0003, put('0, 32'h0000_0003, 8'h72));
    expect_req(27'h42, 32'h0000_0007, put('0, 32'h0000_0007, 8'h73));
    drain(1'b0);

    // flush (R9)
    do_store(27'h50, 32'h0000_00F0, 8'h81); do_commit();
    expect_req(27'h50, 32'h0000_00F0, put('0, 32'h0000_00F0, 8'h81));
    do_store(27'h51, 32'h0000_0F00, 8'h82);
    do_store(27'h52, 32'h0000_F000, 8'h83);
    do_store_flush(27'h53, 32'h000F_0000, 8'h84);
    chk(st_stall == 1'b0 && cmt_stall == 1'b0, "R9 finished queue emptied", st_stall, 0);
    chk(req_valid == 1'b1 && req_addr == 27'h50, "R9 completed entry kept", req_addr, 27'h50);
    do_store(27'h54, 32'h00F0_0000, 8'h85); do_commit(); do_commit();
    expect_req(27'h54, 32'h00F0_0000, put('0, 32'h00F0_0000, 8'h85));
    drain(1'b0);

    // completed queue full (R5)
    for (int i = 0; i < 5; i++) begin
      do_store(27'h60 + AW'(i), 32'h0000_0003, 8'h90 + 8'(i)); do_commit();
    end
    do_store(27'h62, 32'h0000_000C, 8'h99);
    chk(cmt_stall == 1'b0, "R5 merge into full queue allowed", cmt_stall, 0);
    do_commit();
    do_store(27'h65, 32'h0000_0030, 8'h9A);
    chk(cmt_stall == 1'b1, "R5 stall when full and no match", cmt_stall, 1);
    do_commit();
    chk(cmt_stall == 1'b1, "R5 stalled commit ignored", cmt_stall, 1);
    expect_req(27'h60, 32'h0000_0003, put('0, 32'h0000_0003, 8'h90));
    @(negedge clk); req_ready = 1'b1;
    @(negedge clk); req_ready = 1'b0;
    #1;
    chk(cmt_stall == 1'b0, "R5 stall released after pop", cmt_stall, 0);
    do_commit();
    expect_req(27'h61, 32'h0000_0003, put('0, 32'h0000_0003, 8'h91));
    expect_req(27'h62, 32'h0000_000F, put(put('0, 32'h0000_0003, 8'h92), 32'h0000_000C, 8'h99));
    expect_req(27'h63, 32'h0000_0003, put('0, 32'h0000_0003, 8'h93));
    expect_req(27'h64, 32'h0000_0003, put('0, 32'h0000_0003, 8'h94));
    expect_req(27'h65, 32'h0000_0030, put('0, 32'h0000_0030, 8'h9A));
    drain(1'b1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule